// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of a multi-stream audio DMA controller into a single 32-bit status word and one level-sensitive interrupt line. There are two controller-level sources. One is the response ring, whose status flags are qualified by its own enables. The other is the set of codec state-change flags, qualified by a wake-enable mask. Each stream also contributes its own status flags, qualified by that stream's control enables.

The block holds the interrupt control register, which software loads through a simple write strobe. It presents the status word as a read-only value that is recomputed combinationally from its sources. Software clears a source by writing 1 to the flag in that source's own status register, which lives outside this block. The interrupt line is registered. It follows the enabled status one clock after the sources change.

The global status bit summarises every other status bit. It does not gate the line, so it can read 1 while the line stays low.

Top module: `audio_irq_aggr`

## Requirements
- R1: Status bit 30 is 1 whenever (rsp_sts_i & rsp_ctl_i) is non-zero. In both vectors, bit 0 is the response-interrupt flag or enable and bit 1 is the overrun flag or enable.
- R2: Status bit 30 is also 1 whenever (codec_chg_i & wake_en_i) is non-zero. If neither R1 nor R2 applies, bit 30 is 0.
- R3: Status bit n, for n < NUM_STRM, is 1 exactly when the AND of that stream's 3-bit status field and its 3-bit control field is non-zero. Stream n uses bits [3n+2:3n]: bit 0 is completion, bit 1 is FIFO error and bit 2 is descriptor error.
- R4: Status bit 31 is 1 exactly when any of bits 30..0 of the status word is 1.
- R5: irq_o is 1 in the cycle after a clock edge exactly when, at that edge, control bit 31 (global enable) was 1 and (status & control) was non-zero over bit 30 and bits NUM_STRM-1..0.
- R6: Status bit 31 reads 1 while irq_o stays 0 when the pending sources have no matching control enable, or when the global enable is 0.
- R7: When ictl_we_i is 1 at a clock edge, the control register loads ictl_wdata_i. Bits 29..NUM_STRM are not implemented and always read 0.
- R8: After reset, irq_o is 0 and the control register reads 0.
- R9: Status bits 29..NUM_STRM always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rsp_sts_i | input | 2 | Response ring status flags |
| rsp_ctl_i | input | 2 | Response ring interrupt enables |
| codec_chg_i | input | NUM_CODEC | Codec state-change flags |
| wake_en_i | input | NUM_CODEC | Wake-enable mask |
| strm_sts_i | input | 3*NUM_STRM | Per-stream status fields |
| strm_ctl_i | input | 3*NUM_STRM | Per-stream enable fields |
| ictl_we_i | input | 1 | Control register write strobe |
| ictl_wdata_i | input | 32 | Control register write data |
| ictl_o | output | 32 | Control register contents |
| int_sts_o | output | 32 | Interrupt status word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that the source inputs are synchronous to clk_i and hold steady around each rising edge. The bench meets this by changing every input only on the falling edge. The line properties compare irq_o against the status and control values of the previous edge, so they need no assumption about how often the sources toggle. Because the status word is combinational, it is sampled just after each falling-edge drive. The line is sampled just after the following rising edge.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned GIS_BIT = 31;
  localparam int unsigned CIS_BIT = 30;
  localparam int unsigned FLD_W   = 3;  // completion, fifo error, descriptor error
  localparam int unsigned RSP_W   = 2;  // response, overrun
endpackage

// File: rtl/irq_ctl_src.sv
module irq_ctl_src
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_CODEC = 4
) (
  input  logic [RSP_W-1:0]     rsp_sts_i,
  input  logic [RSP_W-1:0]     rsp_ctl_i,
  input  logic [NUM_CODEC-1:0] codec_chg_i,
  input  logic [NUM_CODEC-1:0] wake_en_i,
  output logic                 cis_o
);
  logic rsp_hit, codec_hit;
  always_comb begin
    rsp_hit   = |(rsp_sts_i & rsp_ctl_i);
    codec_hit = |(codec_chg_i & wake_en_i);
    cis_o     = rsp_hit | codec_hit;
  end
endmodule

// File: rtl/irq_strm_src.sv
module irq_strm_src
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_STRM = 8
) (
  input  logic [FLD_W*NUM_STRM-1:0] strm_sts_i,
  input  logic [FLD_W*NUM_STRM-1:0] strm_ctl_i,
  output logic [NUM_STRM-1:0]       strm_hit_o
);
  for (genvar s = 0; s < NUM_STRM; s++) begin : g_strm
    assign strm_hit_o[s] = |(strm_sts_i[FLD_W*s +: FLD_W] & strm_ctl_i[FLD_W*s +: FLD_W]);
  end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_STRM = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] ctl_o
);
  localparam logic [WORD_W-1:0] IMPL_MASK =
    (WORD_W'(1) << GIS_BIT) | (WORD_W'(1) << CIS_BIT) | ((WORD_W'(1) << NUM_STRM) - WORD_W'(1));

  logic [WORD_W-1:0] ctl_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctl_q <= '0;
    else if (we_i) ctl_q <= wdata_i & IMPL_MASK;
  end
  assign ctl_o = ctl_q;

  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctl_o == ($past(wdata_i) & IMPL_MASK)));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_o));
endmodule

// File: rtl/irq_line.sv
module irq_line
  import audio_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] sts_i,
  input  logic [WORD_W-1:0] ctl_i,
  output logic              irq_o
);
  // bit 31 of status is excluded: it must not gate the line
  logic fire;
  assign fire = ctl_i[GIS_BIT] & (|(sts_i[CIS_BIT:0] & ctl_i[CIS_BIT:0]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= fire;
  end

  a_r5_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctl_i[GIS_BIT]));
  a_r6_no_enable_no_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_i[CIS_BIT:0] & ctl_i[CIS_BIT:0]) == '0 |=> !irq_o);
endmodule

// File: rtl/audio_irq_aggr.sv
module audio_irq_aggr
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_STRM  = 8,
  parameter int unsigned NUM_CODEC = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [RSP_W-1:0]          rsp_sts_i,
  input  logic [RSP_W-1:0]          rsp_ctl_i,
  input  logic [NUM_CODEC-1:0]      codec_chg_i,
  input  logic [NUM_CODEC-1:0]      wake_en_i,
  input  logic [FLD_W*NUM_STRM-1:0] strm_sts_i,
  input  logic [FLD_W*NUM_STRM-1:0] strm_ctl_i,
  input  logic                      ictl_we_i,
  input  logic [WORD_W-1:0]         ictl_wdata_i,
  output logic [WORD_W-1:0]         ictl_o,
  output logic [WORD_W-1:0]         int_sts_o,
  output logic                      irq_o
);
  localparam int unsigned PAD_W = CIS_BIT - NUM_STRM;

  logic                cis;
  logic [NUM_STRM-1:0] strm_hit;

  irq_ctl_src #(.NUM_CODEC(NUM_CODEC)) u_ctl_src (
    .rsp_sts_i  (rsp_sts_i),
    .rsp_ctl_i  (rsp_ctl_i),
    .codec_chg_i(codec_chg_i),
    .wake_en_i  (wake_en_i),
    .cis_o      (cis)
  );

  irq_strm_src #(.NUM_STRM(NUM_STRM)) u_strm_src (
    .strm_sts_i(strm_sts_i),
    .strm_ctl_i(strm_ctl_i),
    .strm_hit_o(strm_hit)
  );

  irq_ctl_reg #(.NUM_STRM(NUM_STRM)) u_ctl_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ictl_we_i),
    .wdata_i(ictl_wdata_i),
    .ctl_o  (ictl_o)
  );

  always_comb begin
    int_sts_o = {1'b0, cis, {PAD_W{1'b0}}, strm_hit};
    int_sts_o[GIS_BIT] = |int_sts_o[CIS_BIT:0];
  end

  irq_line u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sts_i (int_sts_o),
    .ctl_i (ictl_o),
    .irq_o (irq_o)
  );

  a_r1_rsp_cis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rsp_sts_i & rsp_ctl_i)) |-> int_sts_o[CIS_BIT]);
  a_r2_codec_cis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(codec_chg_i & wake_en_i)) |-> int_sts_o[CIS_BIT]);
  a_r3_strm0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(strm_sts_i[FLD_W-1:0] & strm_ctl_i[FLD_W-1:0])) == int_sts_o[0]);
  a_r4_gis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sts_o[GIS_BIT] == (int_sts_o[CIS_BIT:0] != '0));
  a_r9_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sts_o[CIS_BIT-1:NUM_STRM] == '0);
endmodule

// File: tb/sim_audio_irq_aggr.sv
module sim_audio_irq_aggr;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NC = 4;

  logic clk = 0, rst_n = 0;
  logic [1:0] rsp_sts = 0, rsp_ctl = 0;
  logic [NC-1:0] chg = 0, wake = 0;
  logic [3*NS-1:0] ssts = 0, sctl = 0;
  logic we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] ictl, sts;
  logic irq;
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_irq_aggr #(.NUM_STRM(NS), .NUM_CODEC(NC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rsp_sts_i(rsp_sts), .rsp_ctl_i(rsp_ctl),
    .codec_chg_i(chg), .wake_en_i(wake), .strm_sts_i(ssts), .strm_ctl_i(sctl),
    .ictl_we_i(we), .ictl_wdata_i(wdata), .ictl_o(ictl), .int_sts_o(sts), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_src();
    @(negedge clk);
    rsp_sts = 0; rsp_ctl = 0; chg = 0; wake = 0; ssts = 0; sctl = 0;
  endtask

  task automatic wr_ctl(logic [31:0] v);
    @(negedge clk); we = 1; wdata = v;
    @(negedge clk); we = 0;
  endtask

  task automatic t_reset();
    #1;
    chk("R8 ictl", ictl, 32'h0);
    chk("R8 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctl_reg();
    wr_ctl(32'hFFFF_FFFF);
    chk("R7 mask", ictl, 32'hC000_00FF);
    wr_ctl(32'h0000_0000);
    chk("R7 clear", ictl, 32'h0);
  endtask

  task automatic t_rsp();
    clear_src();
    rsp_sts = 2'b11; rsp_ctl = 2'b00; #1;
    chk("R1 no enable", sts, 32'h0);
    rsp_ctl = 2'b10; #1;
    chk("R1 overrun", sts, 32'hC000_0000);
    rsp_sts = 2'b01; #1;
    chk("R1 mismatch", sts, 32'h0);
  endtask

  task automatic t_codec();
    clear_src();
    chg = 4'b0101; wake = 4'b1010; #1;
    chk("R2 disjoint", sts, 32'h0);
    wake = 4'b0100; #1;
    chk("R2 hit", sts, 32'hC000_0000);
  endtask

  task automatic t_strm();
    clear_src();
    ssts = {NS{3'b111}}; sctl = 0; #1;
    chk("R3 no enable", sts, 32'h0);
    for (int s = 0; s < NS; s++) begin
      ssts = 0; sctl = 0;
      ssts[3*s + (s % 3)] = 1'b1;
      sctl[3*s + (s % 3)] = 1'b1;
      #1;
      chk($sformatf("R3 stream %0d", s), sts, 32'h8000_0000 | (32'h1 << s));
      chk("R9 pad", {2'b0, sts[29:NS]}, 32'h0);
    end
    ssts = 24'b100_000_000_000_000_000_000_001;
    sctl = 24'b100_000_000_000_000_000_000_010; #1;
    chk("R3 stream7 only", sts, 32'h8000_0080);
  endtask

  task automatic t_gis_no_line();
    clear_src();
    wr_ctl(32'h0000_0000);
    ssts[2:0] = 3'b001; sctl[2:0] = 3'b001;
    @(posedge clk); #1;
    chk("R6 gis set", sts, 32'h8000_0001);
    chk("R6 line low", {31'b0, irq}, 32'h0);
    wr_ctl(32'h0000_0001);  // stream enable, no global enable
    @(posedge clk); #1;
    chk("R6 no gie", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_line();
    clear_src();
    wr_ctl(32'h8000_0004);  // global + stream 2
    @(negedge clk);
    ssts[8:6] = 3'b100; sctl[8:6] = 3'b100; #1;
    chk("R5 before edge", {31'b0, irq}, 32'h0);
    @(posedge clk); #1;
    chk("R5 set", {31'b0, irq}, 32'h1);
    @(negedge clk); ssts[8:6] = 3'b000;
    @(posedge clk); #1;
    chk("R5 clear", {31'b0, irq}, 32'h0);
    // controller source gated by bit 30
    @(negedge clk); rsp_sts = 2'b01; rsp_ctl = 2'b01;
    @(posedge clk); #1;
    chk("R5 cie off", {31'b0, irq}, 32'h0);
    wr_ctl(32'hC000_0000);
    @(posedge clk); #1;
    chk("R5 cie on", {31'b0, irq}, 32'h1);
    wr_ctl(32'h4000_0000);
    @(posedge clk); #1;
    chk("R5 gie off", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 3); t_reset();
        @(negedge clk); rst_n = 1;
        t_ctl_reg();
        t_rsp();
        t_codec();
        t_strm();
        t_gis_no_line();
        t_line();
      end
      begin
        #(CLK_PERIOD * 5000);
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule